// File: doc/BRIEF.md
# Wide-Issue Group Dispatcher

This block sits between the instruction fetch stage and eight functional units of a very-long-instruction-word core. Each cycle the fetch stage may offer one 256-bit word holding eight 32-bit instructions. The dispatcher keeps that word in a one-entry buffer and walks through it. Each cycle it cuts out the next run of instructions that ends at an instruction whose lowest bit is set, or at the last position of the word. It steers every instruction of that run to the functional-unit slot named in its unit field and issues the whole run at once. While it does so it reads the instruction's guard predicate from a small register file and decides whether the slot may actually execute.

A run never extends past the end of the buffered word. The fetch stage is therefore stalled until the final run of the word is leaving. The next word can be taken in that same cycle, so a stream of words issues with no idle cycle between them. Two instructions of one run that name the same unit raise an error flag. The instruction at the lower position keeps the slot.

The control is a two-state machine. In `S_EMPTY` the buffer holds nothing and the fetch handshake is open. In `S_ISSUE` one run leaves each cycle. The transitions are:
- load: `S_EMPTY` to `S_ISSUE`, when a word is accepted.
- advance: `S_ISSUE` to `S_ISSUE`, when the run just issued is not the last of the word.
- chain: `S_ISSUE` to `S_ISSUE`, when the last run issues and a new word is accepted in the same cycle.
- drain: `S_ISSUE` to `S_EMPTY`, when the last run issues and no word is offered.

Top module: `vliw_dispatch`

## Requirements
- R1: Instruction position k of a fetch word occupies `fg_data[32k+31:32k]`, and positions are issued in ascending order.
- R2: Bit 0 of an instruction set to 1 ends the current run. A run spans from the current position through the first such instruction, or through position 7 when none is found.
- R3: A word accepted at a clock edge issues its first run at the next edge. Each further run issues one edge after the previous one.
- R4: `fg_ready` is 1 in `S_EMPTY`. While runs other than the last remain it is 0. It is 1 in the cycle the last run issues, so consecutive words issue with no gap.
- R5: Bits [27:25] of an instruction select its unit u. The issued instruction appears at `iss_instr[32u+31:32u]` with `iss_occ[u]` set. Slots left unused read zero with `iss_occ` clear.
- R6: Bits [31:29] hold a guard code and bit 28 a sense bit. Code 0 is always enabled. Codes 1 to 7 select a predicate register. With sense 0 the slot is enabled when that register is non-zero; with sense 1 it is enabled when the register is zero.
- R7: An instruction whose guard fails still occupies and fills its slot, but its `iss_en` bit is 0.
- R8: If two instructions of one run name the same unit, `iss_conflict` is 1 with that run, and the slot holds the instruction at the lower position.
- R9: With `pw_en` high, `pw_val` is written at the clock edge to predicate register `pw_sel`. Writes to code 0 are discarded. Runs issued after the write see the new value.
- R10: After reset, `fg_ready` is 1, all `iss_*` outputs are 0, and all predicate registers are zero.
- R11: When `iss_valid` is 0, `iss_occ`, `iss_en` and `iss_conflict` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fg_valid | input | 1 | Fetch word offered |
| fg_data | input | 256 | Eight instructions, position 0 in the low bits |
| fg_ready | output | 1 | Dispatcher takes the offered word at this edge |
| pw_en | input | 1 | Predicate write strobe |
| pw_sel | input | 3 | Predicate register written |
| pw_val | input | 32 | Value written |
| iss_valid | output | 1 | A run is issued this cycle |
| iss_occ | output | 8 | Slot carries an instruction |
| iss_en | output | 8 | Slot may execute (guard true) |
| iss_instr | output | 256 | Instruction per unit slot, slot u at bits 32u |
| iss_conflict | output | 1 | Two instructions of the run named one unit |

## Verification
The embedded properties assume only that reset is applied before the first edge and that inputs are two-valued. Buffer hold, pointer advance and enable-within-occupancy are checked against the block's own state. The guard checks further assume that a predicate does not change in the same cycle as the run that reads it. The stimulus respects this by changing `fg_valid`, `fg_data` and the predicate port only away from the clock edge. It also holds a word until it is accepted, and writes predicates only once every expected run has left. Under those conditions the enable a run receives is fixed when the bench predicts it.

// File: rtl/vd_pkg.sv
package vd_pkg;
    // Opcode field placement inside one 32-bit instruction
    localparam int EOB_BIT   = 0;
    localparam int UNIT_LO   = 25;
    localparam int UNIT_W    = 3;
    localparam int SENSE_BIT = 28;
    localparam int GUARD_LO  = 29;
    localparam int GUARD_W   = 3;

    typedef enum logic {
        S_EMPTY = 1'b0,
        S_ISSUE = 1'b1
    } disp_state_e;
endpackage

// File: rtl/vd_group_scan.sv
module vd_group_scan
    import vd_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int IW      = 32,
    parameter int IDX_W   = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS*IW-1:0] fg,
    input  logic [IDX_W-1:0]      start,
    output logic [IDX_W-1:0]      stop,
    output logic [N_SLOTS-1:0]    mask,
    output logic                  at_end
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLOTS - 1);

    logic found;

    // Lowest position at or after start whose end-of-group bit is set
    always_comb begin
        stop  = LAST_IDX;
        found = 1'b0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (!found && (IDX_W'(i) >= start) && fg[i*IW+EOB_BIT]) begin
                stop  = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < N_SLOTS; g++) begin : g_mask
            assign mask[g] = (IDX_W'(g) >= start) && (IDX_W'(g) <= stop);
        end
    endgenerate

    assign at_end = (stop == LAST_IDX);
endmodule

// File: rtl/vd_unit_router.sv
module vd_unit_router
    import vd_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int IW      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SLOTS*IW-1:0] fg,
    input  logic [N_SLOTS-1:0]    mask,
    output logic [N_SLOTS-1:0]    occ,
    output logic [N_SLOTS*IW-1:0] routed,
    output logic                  conflict
);
    logic [N_SLOTS-1:0] multi;

    genvar u;
    generate
        for (u = 0; u < N_SLOTS; u++) begin : g_unit
            int hits;
            // Scan downward so the lowest position is the last writer
            always_comb begin
                hits                 = 0;
                occ[u]               = 1'b0;
                routed[u*IW +: IW]   = '0;
                for (int i = N_SLOTS - 1; i >= 0; i--) begin
                    if (mask[i] && (fg[i*IW+UNIT_LO +: UNIT_W] == UNIT_W'(u))) begin
                        routed[u*IW +: IW] = fg[i*IW +: IW];
                        occ[u]             = 1'b1;
                        hits               = hits + 1;
                    end
                end
                multi[u] = (hits > 1);
            end
        end
    endgenerate

    assign conflict = |multi;

    // Without a clash every member of the run lands in its own slot
    assert_slot_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !conflict |-> ($countones(occ) == $countones(mask)));

    // A clash always leaves fewer occupied slots than run members
    assert_clash_loses_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> ($countones(occ) < $countones(mask)));
endmodule

// File: rtl/vd_guard_eval.sv
module vd_guard_eval
    import vd_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int IW      = 32,
    parameter int PRED_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pw_en,
    input  logic [GUARD_W-1:0]    pw_sel,
    input  logic [PRED_W-1:0]     pw_val,
    input  logic [N_SLOTS*IW-1:0] routed,
    input  logic [N_SLOTS-1:0]    occ,
    output logic [N_SLOTS-1:0]    en
);
    localparam int N_PRED = 2 ** GUARD_W;

    logic [PRED_W-1:0] pred_q [N_PRED];

    // Entry 0 is never written: code 0 means no guard
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < N_PRED; p++) pred_q[p] <= '0;
        end else if (pw_en && (pw_sel != '0)) begin
            pred_q[pw_sel] <= pw_val;
        end
    end

    genvar s;
    generate
        for (s = 0; s < N_SLOTS; s++) begin : g_slot
            logic [GUARD_W-1:0] code;
            logic               sense;
            logic               is_zero;
            assign code    = routed[s*IW+GUARD_LO +: GUARD_W];
            assign sense   = routed[s*IW+SENSE_BIT];
            assign is_zero = (pred_q[code] == '0);
            assign en[s]   = occ[s] && ((code == '0) || (sense ? is_zero : !is_zero));

            assert_uncond_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (occ[s] && (code == '0)) |-> en[s]);
        end
    endgenerate

    assert_pred0_unused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_en && (pw_sel == '0)) |=> (pred_q[0] == '0));
endmodule

// File: rtl/vliw_dispatch.sv
module vliw_dispatch
    import vd_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int IW      = 32,
    parameter int PRED_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fg_valid,
    input  logic [N_SLOTS*IW-1:0] fg_data,
    output logic                  fg_ready,
    input  logic                  pw_en,
    input  logic [GUARD_W-1:0]    pw_sel,
    input  logic [PRED_W-1:0]     pw_val,
    output logic                  iss_valid,
    output logic [N_SLOTS-1:0]    iss_occ,
    output logic [N_SLOTS-1:0]    iss_en,
    output logic [N_SLOTS*IW-1:0] iss_instr,
    output logic                  iss_conflict
);
    localparam int IDX_W = $clog2(N_SLOTS);
    localparam int FG_W  = N_SLOTS * IW;

    disp_state_e        state_q, state_d;
    logic [IDX_W-1:0]   ptr_q;
    logic [FG_W-1:0]    buf_q;
    logic               load;

    logic [IDX_W-1:0]   grp_stop;
    logic [N_SLOTS-1:0] grp_mask;
    logic               grp_last;
    logic [N_SLOTS-1:0] slot_occ;
    logic [FG_W-1:0]    slot_instr;
    logic               slot_clash;
    logic [N_SLOTS-1:0] slot_en;

    vd_group_scan #(.N_SLOTS(N_SLOTS), .IW(IW), .IDX_W(IDX_W)) i_scan (
        .fg     (buf_q),
        .start  (ptr_q),
        .stop   (grp_stop),
        .mask   (grp_mask),
        .at_end (grp_last)
    );

    vd_unit_router #(.N_SLOTS(N_SLOTS), .IW(IW)) i_router (
        .clk      (clk),
        .rst_n    (rst_n),
        .fg       (buf_q),
        .mask     (grp_mask),
        .occ      (slot_occ),
        .routed   (slot_instr),
        .conflict (slot_clash)
    );

    vd_guard_eval #(.N_SLOTS(N_SLOTS), .IW(IW), .PRED_W(PRED_W)) i_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .pw_en  (pw_en),
        .pw_sel (pw_sel),
        .pw_val (pw_val),
        .routed (slot_instr),
        .occ    (slot_occ),
        .en     (slot_en)
    );

    // Next state and fetch handshake
    always_comb begin
        state_d  = state_q;
        fg_ready = 1'b0;
        unique case (state_q)
            S_EMPTY: begin
                fg_ready = 1'b1;
                if (fg_valid) state_d = S_ISSUE;
            end
            S_ISSUE: begin
                fg_ready = grp_last;
                if (grp_last && !fg_valid) state_d = S_EMPTY;
            end
            default: state_d = S_EMPTY;
        endcase
    end

    assign load = fg_valid && fg_ready;

    // State register with fetch buffer and run pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_EMPTY;
            ptr_q   <= '0;
            buf_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                buf_q <= fg_data;
                ptr_q <= '0;
            end else if (state_q == S_ISSUE && !grp_last) begin
                ptr_q <= grp_stop + IDX_W'(1);
            end
        end
    end

    // Registered issue outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iss_valid    <= 1'b0;
            iss_occ      <= '0;
            iss_en       <= '0;
            iss_instr    <= '0;
            iss_conflict <= 1'b0;
        end else if (state_q == S_ISSUE) begin
            iss_valid    <= 1'b1;
            iss_occ      <= slot_occ;
            iss_en       <= slot_en;
            iss_instr    <= slot_instr;
            iss_conflict <= slot_clash;
        end else begin
            iss_valid    <= 1'b0;
            iss_occ      <= '0;
            iss_en       <= '0;
            iss_instr    <= '0;
            iss_conflict <= 1'b0;
        end
    end

    assert_accept_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == S_ISSUE && ptr_q == '0));

    assert_buffer_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ISSUE && !grp_last) |=> $stable(buf_q));

    assert_ptr_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ISSUE && !grp_last) |=> (ptr_q == $past(grp_stop) + IDX_W'(1)));

    assert_en_within_occ_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ((iss_en & ~iss_occ) == '0));

    assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> (iss_occ == '0 && iss_en == '0 && !iss_conflict));
endmodule

// File: tb/test_vliw_dispatch.sv
module test_vliw_dispatch;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fg_valid = 1'b0;
    logic [255:0] fg_data = '0;
    logic         fg_ready;
    logic         pw_en = 1'b0;
    logic [2:0]   pw_sel = '0;
    logic [31:0]  pw_val = '0;
    logic         iss_valid;
    logic [7:0]   iss_occ;
    logic [7:0]   iss_en;
    logic [255:0] iss_instr;
    logic         iss_conflict;

    vliw_dispatch i_vliw_dispatch (
        .clk(clk), .rst_n(rst_n), .fg_valid(fg_valid), .fg_data(fg_data),
        .fg_ready(fg_ready), .pw_en(pw_en), .pw_sel(pw_sel), .pw_val(pw_val),
        .iss_valid(iss_valid), .iss_occ(iss_occ), .iss_en(iss_en),
        .iss_instr(iss_instr), .iss_conflict(iss_conflict)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic [7:0]   occ;
        logic [7:0]   en;
        logic [255:0] instr;
        logic         conf;
        string        tag;
    } exp_t;

    exp_t        sb[$];
    exp_t        cur;
    int          iss_cyc[$];
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    logic [31:0] pm [8];
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] ins(input int g, input int s, input int u,
                                        input int pay, input int e);
        return {3'(g), 1'(s), 3'(u), 24'(pay), 1'(e)};
    endfunction

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    // Monitor: compares issued runs with the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (iss_valid) begin
                iss_cyc.push_back(cyc);
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R3: unexpected issue occ=%h, expected none", iss_occ);
                end else begin
                    cur = sb.pop_front();
                    if (iss_occ !== cur.occ || iss_en !== cur.en ||
                        iss_instr !== cur.instr || iss_conflict !== cur.conf) begin
                        fails++;
                        $display("FAIL %s: occ=%h en=%h conf=%b instr=%h expected occ=%h en=%h conf=%b instr=%h",
                                 cur.tag, iss_occ, iss_en, iss_conflict, iss_instr,
                                 cur.occ, cur.en, cur.conf, cur.instr);
                    end
                end
            end else begin
                check(iss_occ == 0 && iss_en == 0 && !iss_conflict,
                      $sformatf("R11: idle occ=%h en=%h conf=%b expected 0 0 0",
                                iss_occ, iss_en, iss_conflict));
            end
        end
    end

    // Driver: predicts every run of the word, then offers it until accepted
    task automatic send_fg(input logic [255:0] d, input string tag, output int acc);
        int   pos;
        int   stop;
        int   u;
        int   g;
        exp_t e;
        bit   ok;
        pos = 0;
        while (pos < 8) begin
            stop = 7;
            for (int k = 7; k >= pos; k--) if (d[k*32]) stop = k;
            e.occ = '0; e.en = '0; e.instr = '0; e.conf = 1'b0; e.tag = tag;
            for (int k = stop; k >= pos; k--) begin
                u = int'(d[k*32+25 +: 3]);
                if (e.occ[u]) e.conf = 1'b1;
                e.occ[u] = 1'b1;
                e.instr[u*32 +: 32] = d[k*32 +: 32];
            end
            for (int s = 0; s < 8; s++) begin
                g = int'(e.instr[s*32+29 +: 3]);
                ok = (g == 0) ? 1'b1 : (e.instr[s*32+28] ? (pm[g] == 0) : (pm[g] != 0));
                e.en[s] = e.occ[s] && ok;
            end
            sb.push_back(e);
            pos = stop + 1;
        end
        @(negedge clk);
        fg_valid = 1'b1;
        fg_data  = d;
        forever begin
            ok = fg_ready;
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
        end
        #1;
        fg_valid = 1'b0;
        acc = cyc;
    endtask

    task automatic wr_pred(input int sel, input logic [31:0] v);
        @(negedge clk);
        pw_en = 1'b1; pw_sel = 3'(sel); pw_val = v;
        @(posedge clk);
        #1;
        pw_en = 1'b0;
        if (sel != 0) pm[sel] = v;
    endtask

    task automatic drain();
        int t;
        t = 0;
        while (sb.size() != 0 && t < 200) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [255:0] d;
        int a0;
        int a1;
        for (int p = 0; p < 8; p++) pm[p] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(fg_ready == 1'b1, $sformatf("R10: fg_ready=%b expected 1", fg_ready));
        check(iss_valid == 0 && iss_occ == 0 && iss_en == 0 && iss_conflict == 0 && iss_instr == 0,
              $sformatf("R10: iss_valid=%b occ=%h en=%h expected 0", iss_valid, iss_occ, iss_en));
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R5: one run of eight, unit reversed against position
        for (int k = 0; k < 8; k++) d[k*32 +: 32] = ins(0, 0, 7 - k, 16'h1000 + k, (k == 7) ? 1 : 0);
        send_fg(d, "R1 R5 single run", a0);
        drain();

        // R2 R3: every instruction ends its own run
        for (int k = 0; k < 8; k++) d[k*32 +: 32] = ins(0, 0, (k * 3) % 8, 16'h2000 + k, 1);
        send_fg(d, "R2 single-instruction runs", a0);
        drain();

        // R2 R4: runs 0-2, 3-4, 5-7 with no end bit at position 7
        for (int k = 0; k < 8; k++)
            d[k*32 +: 32] = ins(0, 0, k, 16'h3000 + k, (k == 2 || k == 4) ? 1 : 0);
        send_fg(d, "R2 forced end at last position", a0);
        @(negedge clk);
        check(fg_ready == 1'b0, $sformatf("R4: first run, fg_ready=%b expected 0", fg_ready));
        @(negedge clk);
        check(fg_ready == 1'b0, $sformatf("R4: second run, fg_ready=%b expected 0", fg_ready));
        @(negedge clk);
        check(fg_ready == 1'b1, $sformatf("R4: last run, fg_ready=%b expected 1", fg_ready));
        drain();

        // R3 R4: back-to-back words, three runs then two runs
        iss_cyc.delete();
        for (int k = 0; k < 8; k++)
            d[k*32 +: 32] = ins(0, 0, k, 16'h4000 + k, (k == 1 || k == 5) ? 1 : 0);
        send_fg(d, "R3 back-to-back word A", a0);
        for (int k = 0; k < 8; k++)
            d[k*32 +: 32] = ins(0, 0, 7 - k, 16'h5000 + k, (k == 3) ? 1 : 0);
        send_fg(d, "R3 back-to-back word B", a1);
        drain();
        check(a1 == a0 + 3, $sformatf("R4: second accept at %0d expected %0d", a1, a0 + 3));
        check(iss_cyc.size() == 5, $sformatf("R3: %0d issues expected 5", iss_cyc.size()));
        for (int k = 0; k < 5; k++)
            if (k < iss_cyc.size())
                check(iss_cyc[k] == a0 + 1 + k,
                      $sformatf("R3: issue %0d at cycle %0d expected %0d", k, iss_cyc[k], a0 + 1 + k));

        // R6 R7 R10: guards against all-zero predicates
        d[0*32 +: 32] = ins(1, 1, 0, 16'h6000, 0);
        d[1*32 +: 32] = ins(1, 0, 1, 16'h6001, 0);
        d[2*32 +: 32] = ins(0, 1, 2, 16'h6002, 0);
        d[3*32 +: 32] = ins(0, 0, 3, 16'h6003, 1);
        d[4*32 +: 32] = ins(7, 0, 4, 16'h6004, 0);
        d[5*32 +: 32] = ins(7, 1, 5, 16'h6005, 0);
        d[6*32 +: 32] = ins(2, 0, 6, 16'h6006, 0);
        d[7*32 +: 32] = ins(3, 1, 7, 16'h6007, 1);
        send_fg(d, "R6 R7 R10 guards, zero predicates", a0);
        drain();

        // R9 R6: write predicates, including a discarded write to code 0
        wr_pred(1, 32'd5);
        wr_pred(3, 32'h8000_0000);
        wr_pred(7, 32'd1);
        wr_pred(0, 32'hFFFF_FFFF);
        send_fg(d, "R9 R6 guards after predicate writes", a0);
        drain();
        wr_pred(1, 32'd0);
        send_fg(d, "R9 predicate cleared again", a0);
        drain();

        // R8: clash on unit 2, lower position kept; next run clean
        d[0*32 +: 32] = ins(0, 0, 2, 16'h7000, 0);
        d[1*32 +: 32] = ins(0, 0, 5, 16'h7001, 0);
        d[2*32 +: 32] = ins(0, 0, 2, 16'h7002, 1);
        d[3*32 +: 32] = ins(0, 0, 0, 16'h7003, 0);
        d[4*32 +: 32] = ins(0, 0, 1, 16'h7004, 0);
        d[5*32 +: 32] = ins(0, 0, 3, 16'h7005, 0);
        d[6*32 +: 32] = ins(0, 0, 4, 16'h7006, 0);
        d[7*32 +: 32] = ins(3, 1, 6, 16'h7007, 1);
        send_fg(d, "R8 unit clash", a0);
        drain();

        check(sb.size() == 0, $sformatf("R3: %0d runs never issued, expected 0", sb.size()));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule